// File: doc/BRIEF.md
# Mantissa-Exponent Wake-Up Timer

This block produces a periodic wake-up event for a low-power system. It counts pulses of a 1 ms tick and, while enabled, ends a period every M × 2^(R−D) ticks. M is a 14-bit mantissa, R is a 4-bit exponent and D is a 2-bit divisor exponent. The fields are loaded through two 16-bit configuration words on a parallel write port. The timeout repeats until the enable input is cleared.

Every timeout gives a one-cycle pulse and sets a sticky wake flag, which also serves as the interrupt request. Software clears the flag by reading status. The timer also schedules calibration requests for the oscillator that drives it. It requests one each time it is enabled, and then one after every fixed number of ticks while it runs. A control input suppresses the periodic requests only.

Top module: `wake_timer`

## Requirements
- R1: A write with `cfgSel`=0 loads the main word. Bits 11..8 hold the exponent R and bits 7..0 hold mantissa bits 7..0.
- R2: A write with `cfgSel`=1 loads the extension word. Bits 7..6 hold the divisor exponent D and bits 5..0 hold mantissa bits 13..8.
- R3: When R ≥ D, the period is M·2^(R−D) tick pulses, counted from enable or from the last timeout.
- R4: When R < D, the period is M shifted right by D−R, with a floor of one tick when M is nonzero.
- R5: While `enable` is high, timeouts repeat at the programmed period. While `enable` is low, no timeout occurs.
- R6: Each timeout drives `timeoutPulse` high for the cycle after the counting tick and sets `wakeFlag`. `wakeFlag` stays set until it is cleared.
- R7: With M = 0 the timer stays idle and gives no timeout.
- R8: A `statusRd` cycle clears `wakeFlag`. A timeout in that same cycle leaves the flag set.
- R9: `calReq` pulses for one cycle after each rising edge of `enable`.
- R10: While enabled, `calReq` also pulses after every CAL_TICKS tick pulses, counted from the enable edge.
- R11: `calDisable` high suppresses the periodic requests of R10 but not the request of R9.
- R12: A configuration write clears the period count, so the next timeout comes one full period of ticks after the write.
- R13: After reset the words hold 0xE196 and 0xC300 (R=1, D=0, M=150, a 300-tick period), and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickMs | input | 1 | One-cycle pulse per millisecond |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Word select: 0 = main word, 1 = extension word |
| cfgData | input | 16 | Configuration word |
| enable | input | 1 | Timer run enable |
| calDisable | input | 1 | Suppresses periodic calibration requests |
| statusRd | input | 1 | Status read strobe, clears the wake flag |
| timeoutPulse | output | 1 | One-cycle pulse per timeout |
| wakeFlag | output | 1 | Sticky wake status, used as the interrupt request |
| calReq | output | 1 | One-cycle calibration request |

## Verification
The assertions take it that `tickMs`, `statusRd` and `enable` are synchronous single-bit levels. They also take it that a tick arriving in the same cycle as a configuration write or an enable edge is not counted. The stimulus changes inputs only on the falling clock edge. It keeps ticks low in write and enable cycles, and it draws random tick gaps and random field values with small exponents, so every period ends within a few thousand cycles.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCount;  // restart the period count
    logic advance;   // a counting tick this cycle
  } wtStrobes_t;
endpackage

// File: rtl/wake_timer_dp.sv
module wake_timer_dp
  import wake_timer_pkg::*;
#(
  parameter int MANT_LO_W = 8,
  parameter int MANT_HI_W = 6,
  parameter int EXP_W     = 4,
  parameter int DIV_W     = 2,
  parameter int WORD_W    = 16,
  parameter logic [15:0] MAIN_RST = 16'hE196,
  parameter logic [15:0] EXT_RST  = 16'hC300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  input  wtStrobes_t        strobes,
  output logic              hit
);
  localparam int MANT_W    = MANT_LO_W + MANT_HI_W;
  localparam int MAX_SHIFT = (1 << EXP_W) - 1;
  localparam int CNT_W     = MANT_W + MAX_SHIFT;

  logic [MANT_LO_W-1:0] mantLo;
  logic [MANT_HI_W-1:0] mantHi;
  logic [EXP_W-1:0]     expR;
  logic [DIV_W-1:0]     divD;

  // R1 / R2: field capture from the two words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mantLo <= MAIN_RST[MANT_LO_W-1:0];
      expR   <= MAIN_RST[MANT_LO_W +: EXP_W];
      mantHi <= EXT_RST[MANT_HI_W-1:0];
      divD   <= EXT_RST[MANT_HI_W +: DIV_W];
    end else if (cfgWe) begin
      if (cfgSel) begin
        mantHi <= cfgData[MANT_HI_W-1:0];
        divD   <= cfgData[MANT_HI_W +: DIV_W];
      end else begin
        mantLo <= cfgData[MANT_LO_W-1:0];
        expR   <= cfgData[MANT_LO_W +: EXP_W];
      end
    end
  end

  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  divWide;
  logic [CNT_W-1:0]  mantWide, shifted, period, count, nextCount;
  logic              idle;

  assign mant     = {mantHi, mantLo};
  assign divWide  = EXP_W'(divD);
  assign mantWide = CNT_W'(mant);
  assign idle     = (mant == '0);

  // R3 / R4: period in ticks
  always_comb begin
    if (expR >= divWide) shifted = mantWide << (expR - divWide);
    else                 shifted = mantWide >> (divWide - expR);
    if (shifted == '0 && !idle) period = CNT_W'(1);
    else                        period = shifted;
  end

  assign nextCount = count + CNT_W'(1);
  assign hit       = strobes.advance && !strobes.clrCount && !idle && (nextCount >= period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          count <= '0;
    else if (strobes.clrCount)          count <= '0;
    else if (strobes.advance && !idle)  count <= hit ? '0 : nextCount;
  end
endmodule

// File: rtl/wake_timer_ctrl.sv
module wake_timer_ctrl
  import wake_timer_pkg::*;
#(
  parameter int CAL_TICKS = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tickMs,
  input  logic       cfgWe,
  input  logic       calDisable,
  input  logic       statusRd,
  input  logic       hit,
  output wtStrobes_t strobes,
  output logic       timeoutPulse,
  output logic       wakeFlag,
  output logic       calReq
);
  localparam int CAL_W = (CAL_TICKS > 1) ? $clog2(CAL_TICKS) : 1;
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_TICKS - 1);

  logic             enPrev, enRise, calDue;
  logic [CAL_W-1:0] calCount;

  assign enRise = enable && !enPrev;

  // R12 / R5: restart on write, on enable edge, and hold while disabled
  assign strobes.clrCount = cfgWe || enRise || !enable;
  assign strobes.advance  = enable && tickMs;

  assign calDue = enable && !enRise && tickMs && (calCount == CAL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev       <= 1'b0;
      calCount     <= '0;
      calReq       <= 1'b0;
      timeoutPulse <= 1'b0;
      wakeFlag     <= 1'b0;
    end else begin
      enPrev <= enable;
      if (!enable || enRise)  calCount <= '0;
      else if (tickMs)        calCount <= calDue ? '0 : calCount + CAL_W'(1);
      // R9 / R10 / R11
      calReq       <= enRise || (calDue && !calDisable);
      // R6 / R8: a timeout takes priority over a status read
      timeoutPulse <= hit;
      wakeFlag     <= hit || (wakeFlag && !statusRd);
    end
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wake_timer_pkg::*;
#(
  parameter int CAL_TICKS = 40000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickMs,
  input  logic        cfgWe,
  input  logic        cfgSel,
  input  logic [15:0] cfgData,
  input  logic        enable,
  input  logic        calDisable,
  input  logic        statusRd,
  output logic        timeoutPulse,
  output logic        wakeFlag,
  output logic        calReq
);
  wtStrobes_t strobes;
  logic       hit;

  wake_timer_ctrl #(.CAL_TICKS(CAL_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tickMs(tickMs), .cfgWe(cfgWe),
    .calDisable(calDisable), .statusRd(statusRd), .hit(hit), .strobes(strobes),
    .timeoutPulse(timeoutPulse), .wakeFlag(wakeFlag), .calReq(calReq)
  );

  wake_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .strobes(strobes), .hit(hit)
  );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tickMs,
  input logic statusRd,
  input logic timeoutPulse,
  input logic wakeFlag,
  input logic calReq
);
  // R6: a timeout always leaves the flag set
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> wakeFlag);

  // R8: after a read the flag survives only through a new timeout
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && statusRd) |=> (wakeFlag == timeoutPulse));

  // R5: no timeout while disabled
  p_no_run_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !timeoutPulse);

  // R3: timeouts only follow a tick
  p_tick_needed_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tickMs |=> !timeoutPulse);

  // R9: enable edge requests calibration
  p_cal_on_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> calReq);
endmodule

bind wake_timer wake_timer_chk u_chk (.*);

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
  localparam int CAL = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickMs = 1'b0, cfgWe = 1'b0, cfgSel = 1'b0, enable = 1'b0;
  logic calDisable = 1'b0, statusRd = 1'b0;
  logic [15:0] cfgData = '0;
  logic timeoutPulse, wakeFlag, calReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wake_timer #(.CAL_TICKS(CAL)) u_dut (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .enable(enable), .calDisable(calDisable), .statusRd(statusRd),
    .timeoutPulse(timeoutPulse), .wakeFlag(wakeFlag), .calReq(calReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expPeriod(int m, int r, int d);
    int p;
    if (m == 0) return 0;
    if (r >= d) p = m << (r - d);
    else        p = m >> (d - r);
    if (p == 0) p = 1;
    return p;
  endfunction

  task automatic writeCfg(int m, int r, int d);
    @(negedge clk);
    tickMs = 0; cfgWe = 1; cfgSel = 0;
    cfgData = {4'hE, r[3:0], m[7:0]};
    @(negedge clk);
    cfgSel = 1;
    cfgData = {8'hC3, d[1:0], m[13:8]};
    @(negedge clk);
    cfgWe = 0; cfgSel = 0;
  endtask

  task automatic startTimer(string req);
    @(negedge clk);
    tickMs = 0; enable = 1;
    @(negedge clk);
    chk(calReq == 1'b1, req, calReq, 1);
  endtask

  // Counts ticks until a timeout; random gaps between ticks
  task automatic measure(int expTicks, string req, bit dense);
    int ticks = 0;
    bit prevTick = 0;
    bit found = 0;
    for (int i = 0; i < 20000 && !found; i++) begin
      if (i > 0) @(negedge clk);
      if (prevTick) ticks++;
      if (timeoutPulse && i > 0) found = 1;
      else begin
        prevTick = dense ? 1'b1 : ($urandom % 4 != 0);
        tickMs = prevTick;
      end
    end
    tickMs = 0;
    chk(found && ticks == expTicks, req, found ? ticks : -1, expTicks);
  endtask

  task automatic idleTicks(int n, string req, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (timeoutPulse) pulses++;
      tickMs = 1;
    end
    @(negedge clk);
    if (timeoutPulse) pulses++;
    tickMs = 0;
    chk(pulses == 0, req, pulses, 0);
  endtask

  initial begin
    int n, m, r, d, cnt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    chk(!timeoutPulse && !wakeFlag && !calReq, "R13 outputs", {timeoutPulse, wakeFlag, calReq}, 0);
    startTimer("R9 first enable");
    measure(300, "R13 default period", 0);

    // R8 clear, then disable stops timer (R5)
    @(negedge clk); statusRd = 1; @(negedge clk); statusRd = 0;
    chk(wakeFlag == 0, "R8 clear", wakeFlag, 0);
    enable = 0;
    idleTicks(400, "R5 disabled", n);

    // Directed decode corners (R1, R2, R4)
    writeCfg(5, 0, 2);   startTimer("R9"); measure(1, "R4 5>>2", 0);   enable = 0;
    writeCfg(1, 0, 3);   startTimer("R9"); measure(1, "R4 floor", 0);  enable = 0;
    writeCfg(12, 1, 3);  startTimer("R9"); measure(3, "R4 12>>2", 0);  enable = 0;
    writeCfg(259, 0, 0); startTimer("R9"); measure(259, "R2 high mantissa", 0); enable = 0;
    writeCfg(3, 5, 1);   startTimer("R9"); measure(48, "R1 exponent", 0); enable = 0;

    // Random configurations, two periods each (R3, R5)
    for (int t = 0; t < 8; t++) begin
      m = 1 + ($urandom % 40); r = $urandom % 5; d = $urandom % 4;
      writeCfg(m, r, d);
      startTimer("R9 random");
      measure(expPeriod(m, r, d), "R3 random first", 0);
      measure(expPeriod(m, r, d), "R5 repeat", 0);
      enable = 0;
    end

    // R7 idle with zero mantissa
    writeCfg(0, 3, 0); startTimer("R9"); idleTicks(500, "R7 zero mantissa", n); enable = 0;

    // R12 write restarts count
    writeCfg(100, 0, 0); startTimer("R9");
    idleTicks(60, "R12 before write", n);
    writeCfg(100, 0, 0);
    measure(100, "R12 restart", 1);
    enable = 0;

    // R6 / R8 flag behaviour with a one-tick period
    @(negedge clk); statusRd = 1; @(negedge clk); statusRd = 0;
    writeCfg(1, 0, 0); startTimer("R9");
    tickMs = 1; @(negedge clk); tickMs = 0;
    chk(timeoutPulse && wakeFlag, "R6 set", {timeoutPulse, wakeFlag}, 3);
    repeat (3) @(negedge clk);
    chk(wakeFlag && !timeoutPulse, "R6 sticky", {timeoutPulse, wakeFlag}, 1);
    tickMs = 1; statusRd = 1; @(negedge clk);
    chk(wakeFlag == 1, "R8 same-cycle kept", wakeFlag, 1);
    tickMs = 0; @(negedge clk); statusRd = 0;
    chk(wakeFlag == 0, "R8 read clears", wakeFlag, 0);
    enable = 0;

    // R10 periodic calibration
    writeCfg(0, 0, 0); startTimer("R9");
    cnt = 0; n = 0;
    for (int i = 0; i < 1000 && n == 0; i++) begin
      tickMs = 1; @(negedge clk); cnt++;
      if (calReq) n = cnt;
    end
    tickMs = 0;
    chk(n == CAL, "R10 period", n, CAL);
    enable = 0;

    // R11 suppression, with enable request kept
    calDisable = 1;
    startTimer("R11 enable request kept");
    n = 0;
    for (int i = 0; i < 700; i++) begin
      tickMs = 1; @(negedge clk);
      if (calReq) n++;
    end
    tickMs = 0;
    chk(n == 0, "R11 periodic suppressed", n, 0);
    enable = 0; calDisable = 0;

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule